// File: doc/BRIEF.md
# NOR Flash Program and Erase Sequencer

This block turns a byte-range request (plain read, fast read, page program or sector erase) into the series of serial flash commands that carries it out. It sits above a command engine that moves the actual bytes on the wire. The sequencer only decides which opcode, address, length and dummy count go out next, and it waits for the engine to finish each command before it starts the next one.

Program requests are cut into chunks that never cross a page. Every program chunk and every sector erase is preceded by a write enable. After each one the status register is read until the write-in-progress bit clears, and a retry limit on those reads turns a stuck device into a timeout error. A write disable closes every program or erase operation, including one that fails on a timeout. Reads are cut into bounded segments and use no write enable. A request is first checked against the device size and, for erases, against sector alignment. The caller sees `busy` for the whole request and one `done` pulse carrying an error code.

Top module: `nfs_seq`

## Requirements
- R1: During and directly after reset, `busy`, `done` and `cmd_start` are low.
- R2: A request with `req_len` = 0 issues no command and raises `done` one cycle after acceptance with `err` = 0 (none).
- R3: A request whose `req_addr` is at or above `DEV_BYTES`, or whose `req_len` exceeds `DEV_BYTES - req_addr`, issues no command and ends with `err` = 1 (invalid).
- R4: An erase request (`req_op` = 3) whose address or length is not a multiple of 2^`SECTOR_LG` bytes issues no command and ends with `err` = 1.
- R5: A program request (`req_op` = 2) issues opcode 0x02 chunks with `cmd_use_addr` = 1, starting at `req_addr`, each of length min(remaining, 2^`PAGE_LG` - address mod 2^`PAGE_LG`), so no chunk crosses a page.
- R6: Opcode 0x06 (write enable, no address, length 0) is issued directly before every 0x02 and every 0x20 command.
- R7: After every 0x02 or 0x20 command, opcode 0x05 (no address, length 1) is issued repeatedly until a returned `cmd_status` has bit 0 clear; the other status bits are ignored.
- R8: If `POLL_LIMIT` consecutive status reads all show bit 0 set, no further chunk is issued, opcode 0x04 follows, and the request ends with `err` = 2 (timeout).
- R9: Every program or erase request that passes its checks ends with opcode 0x04 (no address, length 0) before `done`, with `err` = 0 when all polls cleared.
- R10: A read request (`req_op` 0 plain, 1 fast) issues only opcode 0x03 with dummy 0, or 0x0B with dummy 8, in consecutive segments of min(remaining, 2^`SEG_LG`) bytes, with no write enable or disable.
- R11: An erase request issues one 0x20 command per 2^`SECTOR_LG`-byte sector, at ascending sector addresses, with `cmd_len` equal to the sector size.
- R12: `busy` stays high from acceptance through the `done` cycle; `req_valid` while busy is ignored, and at most one command is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_op | input | 2 | 0 plain read, 1 fast read, 2 program, 3 sector erase |
| req_addr | input | ADDR_W | Byte offset of the range |
| req_len | input | ADDR_W+1 | Byte count of the range |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | 0 none, 1 invalid request, 2 poll timeout; valid with `done` |
| cmd_start | output | 1 | One-cycle launch of a command to the engine |
| cmd_opcode | output | 8 | Flash opcode |
| cmd_addr | output | ADDR_W | Command address |
| cmd_use_addr | output | 1 | Address phase present |
| cmd_dummy | output | 4 | Dummy cycles after the address |
| cmd_len | output | ADDR_W+1 | Data bytes of the command |
| cmd_done | input | 1 | Engine finished the outstanding command |
| cmd_status | input | 8 | Status byte read by the last status command, valid with `cmd_done` |

## Verification
The hardest situation to reach is the retry limit on status polling: the device has to report write-in-progress exactly `POLL_LIMIT` times in a row, and also one fewer time, in the middle of a multi-chunk program or erase. The bench's engine model holds a per-command busy count that is reloaded on every program or erase opcode, so each request can set how many polls return busy. The bench is built with a small poll limit, pages and sectors, which lets a sweep hit the limit, one below it, and page- and sector-boundary chunking in a few thousand cycles.

// File: rtl/nfs_pkg.sv
package nfs_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_FREAD = 2'd1,
    OP_PROG  = 2'd2,
    OP_ERASE = 2'd3
  } nfs_op_e;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_RANGE   = 2'd1,
    ERR_TIMEOUT = 2'd2
  } nfs_err_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WREN = 3'd1,
    ST_MAIN = 3'd2,
    ST_POLL = 3'd3,
    ST_WRDI = 3'd4,
    ST_DONE = 3'd5
  } nfs_state_e;

  localparam logic [7:0] FC_WREN   = 8'h06;
  localparam logic [7:0] FC_WRDI   = 8'h04;
  localparam logic [7:0] FC_RDSR   = 8'h05;
  localparam logic [7:0] FC_PROG   = 8'h02;
  localparam logic [7:0] FC_SERASE = 8'h20;
  localparam logic [7:0] FC_READ   = 8'h03;
  localparam logic [7:0] FC_FREAD  = 8'h0B;
  localparam logic [3:0] FAST_DUMMY = 4'd8;
endpackage

// File: rtl/nfs_rst_sync.sv
module nfs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= 2'b00;
    else        shift_q <= {shift_q[0], 1'b1};
  end

  assign rst_n_sync = shift_q[1];
endmodule

// File: rtl/nfs_range_check.sv
module nfs_range_check #(
  parameter int ADDR_W    = 24,
  parameter int DEV_BYTES = 983040,
  parameter int SECTOR_LG = 12,
  localparam int LEN_W    = ADDR_W + 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic              is_erase,
  output logic              bad
);
  localparam logic [LEN_W-1:0] DEV = LEN_W'(DEV_BYTES);

  logic [LEN_W-1:0] addr_ext;
  logic             past_end, too_long, misaligned;

  always_comb begin
    addr_ext   = {1'b0, addr};
    past_end   = addr_ext >= DEV;
    too_long   = len > (DEV - addr_ext);
    misaligned = is_erase && ((|addr[SECTOR_LG-1:0]) || (|len[SECTOR_LG-1:0]));
    bad        = past_end || too_long || misaligned;
  end
endmodule

// File: rtl/nfs_chunker.sv
module nfs_chunker
  import nfs_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int PAGE_LG   = 8,
  parameter int SECTOR_LG = 12,
  parameter int SEG_LG    = 15,
  localparam int LEN_W    = ADDR_W + 1
) (
  input  nfs_op_e           op,
  input  logic [ADDR_W-1:0] cur,
  input  logic [LEN_W-1:0]  remain,
  output logic [LEN_W-1:0]  chunk
);
  localparam logic [LEN_W-1:0] PAGE   = LEN_W'(1) << PAGE_LG;
  localparam logic [LEN_W-1:0] SECTOR = LEN_W'(1) << SECTOR_LG;
  localparam logic [LEN_W-1:0] SEG    = LEN_W'(1) << SEG_LG;

  logic [LEN_W-1:0] room;

  always_comb begin
    // Bytes left before the next page boundary.
    room = PAGE - LEN_W'(cur[PAGE_LG-1:0]);
    case (op)
      OP_PROG:  chunk = (remain < room) ? remain : room;
      OP_ERASE: chunk = SECTOR;
      default:  chunk = (remain < SEG) ? remain : SEG;
    endcase
  end
endmodule

// File: rtl/nfs_seq.sv
module nfs_seq
  import nfs_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DEV_BYTES  = 983040,
  parameter int PAGE_LG    = 8,
  parameter int SECTOR_LG  = 12,
  parameter int SEG_LG     = 15,
  parameter int POLL_LIMIT = 10000,
  localparam int LEN_W     = ADDR_W + 1,
  localparam int PCW       = $clog2(POLL_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err,
  output logic              cmd_start,
  output logic [7:0]        cmd_opcode,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_use_addr,
  output logic [3:0]        cmd_dummy,
  output logic [LEN_W-1:0]  cmd_len,
  input  logic              cmd_done,
  input  logic [7:0]        cmd_status
);
  logic rst_ni;

  nfs_state_e        st_q, st_d;
  logic              wait_q, wait_d;
  nfs_op_e           op_q, op_d;
  logic [ADDR_W-1:0] cur_q, cur_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [PCW-1:0]    poll_q, poll_d;
  logic [1:0]        err_q, err_d;
  logic [LEN_W-1:0]  chunk;
  logic              req_bad, accept, resp, ctx_en, is_read, launching;

  nfs_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ni));

  nfs_range_check #(
    .ADDR_W(ADDR_W), .DEV_BYTES(DEV_BYTES), .SECTOR_LG(SECTOR_LG)
  ) u_range (
    .addr(req_addr), .len(req_len),
    .is_erase(req_op == 2'(OP_ERASE)), .bad(req_bad)
  );

  nfs_chunker #(
    .ADDR_W(ADDR_W), .PAGE_LG(PAGE_LG), .SECTOR_LG(SECTOR_LG), .SEG_LG(SEG_LG)
  ) u_chunk (
    .op(op_q), .cur(cur_q), .remain(rem_q), .chunk(chunk)
  );

  assign is_read   = !op_q[1];
  assign launching = (st_q inside {ST_WREN, ST_MAIN, ST_POLL, ST_WRDI}) && !wait_q;
  assign accept    = (st_q == ST_IDLE) && req_valid;
  assign resp      = wait_q && cmd_done;
  assign ctx_en    = accept || resp;

  // Next-state logic.
  always_comb begin
    st_d   = st_q;
    wait_d = wait_q;
    op_d   = op_q;
    cur_d  = cur_q;
    rem_d  = rem_q;
    poll_d = poll_q;
    err_d  = err_q;
    if (launching) wait_d = 1'b1;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          op_d   = nfs_op_e'(req_op);
          cur_d  = req_addr;
          rem_d  = req_len;
          poll_d = '0;
          err_d  = 2'(ERR_NONE);
          if (req_len == '0) begin
            st_d = ST_DONE;
          end else if (req_bad) begin
            err_d = 2'(ERR_RANGE);
            st_d  = ST_DONE;
          end else begin
            st_d = req_op[1] ? ST_WREN : ST_MAIN;
          end
        end
      end
      ST_WREN: if (resp) begin
        wait_d = 1'b0;
        st_d   = ST_MAIN;
      end
      ST_MAIN: if (resp) begin
        wait_d = 1'b0;
        cur_d  = cur_q + chunk[ADDR_W-1:0];
        rem_d  = rem_q - chunk;
        if (is_read) begin
          st_d = (rem_q == chunk) ? ST_DONE : ST_MAIN;
        end else begin
          poll_d = '0;
          st_d   = ST_POLL;
        end
      end
      ST_POLL: if (resp) begin
        wait_d = 1'b0;
        if (!cmd_status[0]) begin
          st_d = (rem_q == '0) ? ST_WRDI : ST_WREN;
        end else if (poll_q == PCW'(POLL_LIMIT - 1)) begin
          err_d = 2'(ERR_TIMEOUT);
          st_d  = ST_WRDI;
        end else begin
          poll_d = poll_q + 1'b1;
        end
      end
      ST_WRDI: if (resp) begin
        wait_d = 1'b0;
        st_d   = ST_DONE;
      end
      default: begin
        wait_d = 1'b0;
        st_d   = ST_IDLE;
      end
    endcase
  end

  // Control registers.
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      wait_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      wait_q <= wait_d;
    end
  end

  // Request context, loaded on acceptance and on each command response.
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_READ;
      cur_q  <= '0;
      rem_q  <= '0;
      poll_q <= '0;
      err_q  <= '0;
    end else if (ctx_en) begin
      op_q   <= op_d;
      cur_q  <= cur_d;
      rem_q  <= rem_d;
      poll_q <= poll_d;
      err_q  <= err_d;
    end
  end

  // Command fields.
  always_comb begin
    cmd_opcode   = FC_WRDI;
    cmd_addr     = '0;
    cmd_use_addr = 1'b0;
    cmd_dummy    = '0;
    cmd_len      = '0;
    case (st_q)
      ST_WREN: cmd_opcode = FC_WREN;
      ST_POLL: begin
        cmd_opcode = FC_RDSR;
        cmd_len    = LEN_W'(1);
      end
      ST_MAIN: begin
        cmd_addr     = cur_q;
        cmd_use_addr = 1'b1;
        cmd_len      = chunk;
        case (op_q)
          OP_PROG:  cmd_opcode = FC_PROG;
          OP_ERASE: cmd_opcode = FC_SERASE;
          OP_FREAD: begin
            cmd_opcode = FC_FREAD;
            cmd_dummy  = FAST_DUMMY;
          end
          default:  cmd_opcode = FC_READ;
        endcase
      end
      default: ;
    endcase
  end

  assign cmd_start = launching;
  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_DONE);
  assign err       = err_q;
endmodule

// File: rtl/nfs_seq_checker.sv
module nfs_seq_checker #(
  parameter int ADDR_W  = 24,
  parameter int PAGE_LG = 8,
  parameter int SEG_LG  = 15,
  localparam int LEN_W  = ADDR_W + 1,
  localparam int LW1    = LEN_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [1:0]        err,
  input logic              cmd_start,
  input logic [7:0]        cmd_opcode,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [LEN_W-1:0]  cmd_len,
  input logic              cmd_done
);
  logic       out_q;
  logic [7:0] last_op_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q     <= 1'b0;
      last_op_q <= 8'h00;
    end else begin
      if (cmd_start)     out_q <= 1'b1;
      else if (cmd_done) out_q <= 1'b0;
      if (cmd_start) last_op_q <= cmd_opcode;
    end
  end

  a_r12_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> busy);

  a_r12_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> !out_q);

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_page_fit: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && cmd_opcode == 8'h02) |->
      ((LW1'(cmd_len) + LW1'(cmd_addr[PAGE_LG-1:0])) <= (LW1'(1) << PAGE_LG)) && (cmd_len != '0));

  a_r10_seg_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && (cmd_opcode == 8'h03 || cmd_opcode == 8'h0B)) |->
      (LW1'(cmd_len) <= (LW1'(1) << SEG_LG)) && (cmd_len != '0));

  a_r6_wren_first: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && (cmd_opcode == 8'h02 || cmd_opcode == 8'h20)) |-> (last_op_q == 8'h06));

  a_r8_timeout_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err == 2'd2) |-> (last_op_q == 8'h04));
endmodule

bind nfs_seq nfs_seq_checker #(
  .ADDR_W(ADDR_W), .PAGE_LG(PAGE_LG), .SEG_LG(SEG_LG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .cmd_start(cmd_start), .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr),
  .cmd_len(cmd_len), .cmd_done(cmd_done)
);

// File: tb/sim_nfs_seq.sv
module sim_nfs_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 12;
  localparam int LW   = AW + 1;
  localparam int DEV  = 256;
  localparam int PLG  = 4;
  localparam int SLG  = 6;
  localparam int GLG  = 5;
  localparam int LIM  = 4;
  localparam int PAGE = 1 << PLG;
  localparam int SECT = 1 << SLG;
  localparam int SEG  = 1 << GLG;
  localparam int MAXLOG = 512;
  localparam int WD_LIMIT = 190000;

  logic          clk, rst_n, req_valid;
  logic [1:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [LW-1:0] req_len;
  logic          busy, done;
  logic [1:0]    err;
  logic          cmd_start, cmd_use_addr, cmd_done;
  logic [7:0]    cmd_opcode, cmd_status;
  logic [AW-1:0] cmd_addr;
  logic [3:0]    cmd_dummy;
  logic [LW-1:0] cmd_len;

  nfs_seq #(
    .ADDR_W(AW), .DEV_BYTES(DEV), .PAGE_LG(PLG), .SECTOR_LG(SLG),
    .SEG_LG(GLG), .POLL_LIMIT(LIM)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_len(req_len), .busy(busy), .done(done), .err(err),
    .cmd_start(cmd_start), .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr),
    .cmd_use_addr(cmd_use_addr), .cmd_dummy(cmd_dummy), .cmd_len(cmd_len),
    .cmd_done(cmd_done), .cmd_status(cmd_status)
  );

  int nvec = 0, nmis = 0, cycles = 0;

  // Engine model log and expected command list.
  int lg_op[MAXLOG], lg_addr[MAXLOG], lg_use[MAXLOG], lg_dum[MAXLOG], lg_len[MAXLOG];
  int ex_op[MAXLOG], ex_addr[MAXLOG], ex_use[MAXLOG], ex_dum[MAXLOG], ex_len[MAXLOG];
  int lg_n = 0, ex_n = 0, ex_err = 0;
  int bn_cfg = 0, polls_left = 0, lat = 0;
  logic [7:0] pend_st = 8'h00;

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WD_LIMIT) begin
        nmis++;
        $display("FAIL watchdog: actual %0d cycles, expected below %0d", cycles, WD_LIMIT);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
      end
    end
  end

  always @(negedge clk) begin
    cmd_done = 1'b0;
    if (lat > 0) begin
      lat--;
      if (lat == 0) begin
        cmd_done   = 1'b1;
        cmd_status = pend_st;
      end
    end
    if (cmd_start) begin
      if (lg_n < MAXLOG) begin
        lg_op[lg_n] = int'(cmd_opcode); lg_addr[lg_n] = int'(cmd_addr);
        lg_use[lg_n] = int'(cmd_use_addr); lg_dum[lg_n] = int'(cmd_dummy);
        lg_len[lg_n] = int'(cmd_len);
        lg_n++;
      end
      if (cmd_opcode == 8'h02 || cmd_opcode == 8'h20) polls_left = bn_cfg;
      if (cmd_opcode == 8'h05) begin
        pend_st = (polls_left > 0) ? 8'h81 : 8'h7E;
        if (polls_left > 0) polls_left--;
      end else begin
        pend_st = 8'h00;
      end
      lat = 2;
    end
  end

  function automatic string tag_of(int o);
    case (o)
      8'h02: return "R5";
      8'h20: return "R11";
      8'h06: return "R6";
      8'h05: return "R7";
      8'h04: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic push(int o, int a, int u, int d, int l);
    if (ex_n < MAXLOG) begin
      ex_op[ex_n] = o; ex_addr[ex_n] = a; ex_use[ex_n] = u;
      ex_dum[ex_n] = d; ex_len[ex_n] = l;
      ex_n++;
    end
  endtask

  task automatic build_exp(int op, int addr, int len, int bn);
    int a = addr;
    int r = len;
    bit to = 0;
    ex_n = 0;
    ex_err = 0;
    if (len == 0) return;
    if (addr >= DEV || len > DEV - addr || (op == 3 && ((addr % SECT) != 0 || (len % SECT) != 0))) begin
      ex_err = 1;
      return;
    end
    if (op < 2) begin
      while (r > 0) begin
        int c = (r < SEG) ? r : SEG;
        push(op == 0 ? 8'h03 : 8'h0B, a, 1, op == 0 ? 0 : 8, c);
        a += c; r -= c;
      end
      return;
    end
    while (r > 0 && !to) begin
      int room = PAGE - (a % PAGE);
      int c = (op == 2) ? ((r < room) ? r : room) : SECT;
      push(8'h06, 0, 0, 0, 0);
      push(op == 2 ? 8'h02 : 8'h20, a, 1, 0, c);
      a += c; r -= c;
      if (bn >= LIM) begin
        for (int k = 0; k < LIM; k++) push(8'h05, 0, 0, 0, 1);
        to = 1;
      end else begin
        for (int k = 0; k <= bn; k++) push(8'h05, 0, 0, 0, 1);
      end
    end
    push(8'h04, 0, 0, 0, 0);
    ex_err = to ? 2 : 0;
  endtask

  task automatic check(bit ok, string tag, string what, int act, int exp);
    nvec++;
    if (!ok) begin
      nmis++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Issue one request and wait for done; returns cycles from acceptance to done.
  task automatic issue(int op, int addr, int len, output int cyc);
    @(negedge clk);
    lg_n = 0;
    req_valid = 1'b1;
    req_op    = 2'(op);
    req_addr  = AW'(addr);
    req_len   = LW'(len);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic compare(string etag);
    check(int'(err) == ex_err, etag, "err", int'(err), ex_err);
    check(lg_n == ex_n, ex_n > 0 ? tag_of(ex_op[0]) : etag, "command count", lg_n, ex_n);
    for (int i = 0; i < ex_n && i < lg_n; i++) begin
      bit ok = (lg_op[i] == ex_op[i]) && (lg_use[i] == ex_use[i]) &&
               (lg_dum[i] == ex_dum[i]) && (lg_len[i] == ex_len[i]) &&
               (ex_use[i] == 0 || lg_addr[i] == ex_addr[i]);
      check(ok, tag_of(ex_op[i]), $sformatf("cmd %0d op/addr/len", i),
            lg_op[i] * 65536 + lg_addr[i], ex_op[i] * 65536 + ex_addr[i]);
    end
  endtask

  task automatic run_req(int op, int addr, int len, int bn, string etag);
    int cyc;
    bn_cfg = bn;
    build_exp(op, addr, len, bn);
    issue(op, addr, len, cyc);
    check(done === 1'b1, "R12", "done seen", int'(done), 1);
    compare(etag);
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R12", "idle after done", int'(busy), 0);
  endtask

  initial begin
    int cyc;
    int paddr[9] = '{0, 1, 7, 15, 16, 30, 200, 240, 250};
    int plen[6]  = '{1, 2, 15, 16, 17, 40};
    int raddr[4] = '{0, 5, 224, 255};
    int rlen[5]  = '{1, 31, 32, 33, 100};
    int elen[5]  = '{0, 16, 64, 128, 192};
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_len = '0;
    cmd_done = 1'b0; cmd_status = 8'h00;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && cmd_start === 1'b0, "R1", "reset outputs",
          int'(busy) + int'(done) + int'(cmd_start), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && cmd_start === 1'b0, "R1", "after release",
          int'(busy) + int'(done) + int'(cmd_start), 0);

    // R2: zero length completes one cycle after acceptance with no commands.
    for (int op = 0; op < 4; op++) begin
      issue(op, 8, 0, cyc);
      check(cyc == 1, "R2", "zero-length latency", cyc, 1);
      check(lg_n == 0 && int'(err) == 0, "R2", "zero-length commands", lg_n, 0);
    end

    // R5/R6/R7/R9 program sweep, out-of-range cases give R3.
    foreach (paddr[i]) foreach (plen[j])
      run_req(2, paddr[i], plen[j], (paddr[i] + plen[j]) % 3, "R3");
    run_req(2, 0, 256, 0, "R5");

    // R11/R4/R3 erase sweep.
    for (int a = 0; a <= DEV; a += 16)
      foreach (elen[j]) run_req(3, a, elen[j], a % 2, "R4");

    // R10 read sweep, plain and fast.
    for (int op = 0; op < 2; op++)
      foreach (raddr[i]) foreach (rlen[j]) run_req(op, raddr[i], rlen[j], 0, "R3");
    run_req(0, 0, 256, 0, "R10");
    run_req(1, 300, 4, 0, "R3");

    // R8: poll limit hit, and one below it.
    run_req(2, 3, 20, LIM, "R8");
    run_req(2, 3, 20, LIM - 1, "R8");
    run_req(3, 64, 128, LIM, "R8");
    run_req(3, 64, 128, LIM - 1, "R8");

    // R12: a request raised while busy is ignored.
    bn_cfg = 1;
    build_exp(2, 0, 20, 1);
    @(negedge clk);
    lg_n = 0;
    req_valid = 1'b1; req_op = 2'd2; req_addr = '0; req_len = LW'(20);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(busy === 1'b1, "R12", "busy during request", int'(busy), 1);
    req_valid = 1'b1; req_op = 2'd3; req_addr = '0; req_len = LW'(64);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    compare("R12");
    repeat (10) @(negedge clk);
    check(busy === 1'b0 && lg_n == ex_n, "R12", "no command after ignored request", lg_n, ex_n);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end
endmodule